// File: doc/BRIEF.md
# Memory Traffic Self-Test Sequencer

This block is a built-in self test for a memory controller. It drives a memory-mapped master port with pipelined reads, waitrequest flow control and bursts. It runs a fixed series of test phases. In each phase it performs a set number of operations, and every operation writes one word or one burst of words and then reads the same words back. The phases run in this order:

1. single-word operations with sequential addresses
2. single-word operations with random addresses
3. single-word operations with mixed addresses
4. burst operations with sequential addresses
5. burst operations with random addresses
6. burst operations with mixed addresses

A phase whose operation count is zero is skipped.

Random addresses come from a 32-bit Galois LFSR. In the mixed phases the same LFSR also decides, operation by operation, between the next sequential address and a random one, weighted by a parameter. Each write word is a function of its address and of a running operation tag. For every read command it accepts, the sequencer pushes a descriptor into a small queue. The descriptor holds the base address, the length and the tag. A comparator rebuilds the expected word for each returning beat from the descriptor at the head of the queue.

When every phase is complete and every beat has matched, the block settles in a pass state. If any beat mismatches, the block stops starting new operations, lets the outstanding reads return, and settles in a fail state. Both end states hold until reset.

Top module: `mem_bist_seq`

## Requirements
- R1: While reset is held, mm_read, mm_write, test_pass and test_fail are all 0.
- R2: Phases run in the order single/sequential, single/random, single/mixed, block/sequential, block/random, block/mixed. Each phase performs exactly its parameterised number of operations, and a phase with a count of zero issues nothing.
- R3: Each operation first writes its beats as one write command with mm_burstcount equal to the length (1 for single operations, BURST for block operations). Once all write beats are accepted, it issues exactly one read command with the same base address and burstcount. No read is asserted while write beats remain.
- R4: The sequential pointer starts at 0 after reset. It is shared by all phases and advances by the length of each operation that uses it, wrapping at 2^ADDR_W. Beat i of a burst targets base + i.
- R5: The LFSR starts at SEED. It advances as s' = (s >> 1) XOR (s[0] ? 0x80200003 : 0) exactly once per random or mixed operation. A random base address is the low ADDR_W bits of the advanced state.
- R6: In a mixed phase, the operation takes the sequential pointer when bits [31:24] of the advanced LFSR state are below MIX_SEQ_WEIGHT, and otherwise takes the random address. Both choices occur.
- R7: The write word for address a of the operation with tag t is (a × 0x9E3779B1) XOR {t[15:0], 0x5A5A}, truncated to DATA_W. The tag counts operations from 0 after reset.
- R8: While mm_waitrequest is 1, an asserted command holds mm_read, mm_write, mm_address, mm_burstcount and mm_writedata unchanged into the next cycle.
- R9: At most QDEPTH read commands are outstanding. When QDEPTH are outstanding and a read is due, mm_read stays low until a command completes.
- R10: test_pass rises only after every operation is done and no read is outstanding. It then stays 1 with no further commands.
- R11: After a mismatching beat, at most one further operation is started. test_fail rises only once no read is outstanding, stays 1, and test_pass never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mm_waitrequest | input | 1 | Slave stall; the command is accepted on a cycle where it is 0 |
| mm_read | output | 1 | Read command |
| mm_write | output | 1 | Write beat |
| mm_address | output | ADDR_W | Word address of the command (burst base) |
| mm_writedata | output | DATA_W | Write beat data |
| mm_burstcount | output | $clog2(BURST+1) | Beats in the command |
| mm_readdata | input | DATA_W | Read beat data |
| mm_readdatavalid | input | 1 | Read beat valid |
| test_pass | output | 1 | Terminal pass state |
| test_fail | output | 1 | Terminal fail state |

## Verification
The first write beat of an operation appears in the cycle after the sequencer picks its address. That cycle is two clock edges after the previous read was accepted, so the bench predicts each base address and burst length at the first write cycle it sees, and it checks data on each cycle where a beat is accepted. The read command may follow on any cycle after the last write beat is accepted, and the verdict arrives one cycle after the queue drains. The bench therefore follows the handshakes event by event instead of fixed delays, and it counts outstanding commands against QDEPTH in the same cycle the DUT sees them. All port samples are taken at the falling edge, so each value seen is the one the responder acts on at the next rising edge.

// File: rtl/mem_bist_pkg.sv
package mem_bist_pkg;

  localparam int TAG_W      = 16;
  localparam int LFSR_W     = 32;
  localparam int NUM_PHASES = 6;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 32'h8020_0003;

  typedef enum logic [1:0] {AM_SEQ, AM_RAND, AM_MIX} addr_mode_e;

  typedef enum logic [2:0] {
    ST_PICK, ST_WR, ST_RD, ST_DRAIN, ST_PASS, ST_FAIL
  } seq_state_e;

  // Galois step, right-shifting form
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
  endfunction

  // Data word as a function of address and operation tag
  function automatic logic [31:0] pattern_word(input logic [31:0] addr,
                                               input logic [TAG_W-1:0] tag);
    return (addr * 32'h9E37_79B1) ^ {tag, 16'h5A5A};
  endfunction

  function automatic logic mix_pick_seq(input logic [LFSR_W-1:0] s,
                                        input logic [7:0] weight);
    return s[31:24] < weight;
  endfunction

  function automatic addr_mode_e phase_mode(input logic [2:0] p);
    case (p)
      3'd0, 3'd3: return AM_SEQ;
      3'd1, 3'd4: return AM_RAND;
      default:    return AM_MIX;
    endcase
  endfunction

  function automatic logic phase_is_block(input logic [2:0] p);
    return p >= 3'd3;
  endfunction

endpackage

// File: rtl/mem_bist_addr.sv
module mem_bist_addr
  import mem_bist_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BURST  = 8,
  parameter logic [31:0] SEED = 32'hACE1_2468,
  parameter logic [7:0]  MIX_SEQ_WEIGHT = 8'd128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  addr_mode_e        mode_i,
  input  logic              block_i,
  output logic [ADDR_W-1:0] base_o
);

  logic [LFSR_W-1:0] lfsr_q, lfsr_adv;
  logic [ADDR_W-1:0] seq_q, seq_inc;
  logic              use_seq;
  logic              uses_lfsr;

  always_comb begin
    lfsr_adv  = lfsr_next(lfsr_q);
    uses_lfsr = (mode_i != AM_SEQ);
    case (mode_i)
      AM_SEQ:  use_seq = 1'b1;
      AM_RAND: use_seq = 1'b0;
      default: use_seq = mix_pick_seq(lfsr_adv, MIX_SEQ_WEIGHT);
    endcase
    seq_inc = block_i ? ADDR_W'(BURST) : ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      seq_q  <= '0;
      base_o <= '0;
    end else if (step_i) begin
      if (uses_lfsr) lfsr_q <= lfsr_adv;
      if (use_seq) begin
        base_o <= seq_q;
        seq_q  <= seq_q + seq_inc;
      end else begin
        base_o <= lfsr_adv[ADDR_W-1:0];
      end
    end
  end

  // R5: a maximal-length LFSR never reaches the all-zero lock-up state
  a_r5_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> lfsr_q != '0);

endmodule

// File: rtl/mem_bist_expq.sv
module mem_bist_expq #(
  parameter int W     = 27,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = slot_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        slot_q[wr_q] <= din_i;
        wr_q         <= bump(wr_q);
      end
      if (pop_i) rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9: no descriptor may be pushed into a full queue
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/mem_bist_cmp.sv
module mem_bist_cmp
  import mem_bist_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int BURST  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              q_empty_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic              head_blk_i,
  input  logic [TAG_W-1:0]  head_tag_i,
  output logic              pop_o,
  output logic              mismatch_o,
  output logic              err_o
);

  localparam int BC_W = $clog2(BURST + 1);

  logic [BC_W-1:0]   beat_q, head_len;
  logic [ADDR_W-1:0] beat_addr;
  logic [DATA_W-1:0] expect_word;
  logic              last_beat;

  always_comb begin
    head_len    = head_blk_i ? BC_W'(BURST) : BC_W'(1);
    beat_addr   = head_addr_i + ADDR_W'(beat_q);
    expect_word = DATA_W'(pattern_word(32'(beat_addr), head_tag_i));
    last_beat   = (beat_q == head_len - 1'b1);
    mismatch_o  = rdvalid_i && (q_empty_i || rdata_i != expect_word);
    pop_o       = rdvalid_i && !q_empty_i && last_beat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q <= '0;
      err_o  <= 1'b0;
    end else begin
      if (mismatch_o) err_o <= 1'b1;
      if (pop_o)          beat_q <= '0;
      else if (rdvalid_i) beat_q <= beat_q + 1'b1;
    end
  end

  // R11: once recorded, an error never clears before reset
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_o));
  // R3: the beat index never runs past the head command's length
  a_r3_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !q_empty_i |-> beat_q < head_len);

endmodule

// File: rtl/mem_bist_seq.sv
module mem_bist_seq
  import mem_bist_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int BURST  = 8,
  parameter int QDEPTH = 4,
  parameter int N_SS   = 4,
  parameter int N_SR   = 4,
  parameter int N_SM   = 6,
  parameter int N_BS   = 3,
  parameter int N_BR   = 3,
  parameter int N_BM   = 4,
  parameter logic [7:0]  MIX_SEQ_WEIGHT = 8'd128,
  parameter logic [31:0] SEED = 32'hACE1_2468,
  localparam int BC_W = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mm_waitrequest,
  output logic              mm_read,
  output logic              mm_write,
  output logic [ADDR_W-1:0] mm_address,
  output logic [DATA_W-1:0] mm_writedata,
  output logic [BC_W-1:0]   mm_burstcount,
  input  logic [DATA_W-1:0] mm_readdata,
  input  logic              mm_readdatavalid,
  output logic              test_pass,
  output logic              test_fail
);

  localparam int DESC_W = ADDR_W + 1 + TAG_W;
  localparam logic [2:0] PH_END = 3'(NUM_PHASES);

  function automatic int unsigned phase_ops(input int p);
    case (p)
      0: return N_SS;
      1: return N_SR;
      2: return N_SM;
      3: return N_BS;
      4: return N_BR;
      5: return N_BM;
      default: return 0;
    endcase
  endfunction

  // first phase at or after 'from' with a nonzero count
  function automatic logic [2:0] next_live(input int from);
    logic [2:0] r;
    r = PH_END;
    for (int i = NUM_PHASES - 1; i >= 0; i--)
      if (i >= from && phase_ops(i) != 0) r = 3'(i);
    return r;
  endfunction

  seq_state_e        state_q;
  logic [2:0]        phase_q;
  logic [15:0]       opcnt_q;
  logic [BC_W-1:0]   beat_q;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] base_q;

  // named internal events
  logic              op_pick;
  logic              wr_beat_acc;
  logic              rd_cmd_acc;
  logic              last_wr_beat;
  logic              phase_done;

  logic              cur_block;
  addr_mode_e        cur_mode;
  logic [BC_W-1:0]   op_len;
  logic [ADDR_W-1:0] wr_addr;

  logic              q_full, q_empty, q_pop;
  logic [DESC_W-1:0] q_head;
  logic              cmp_err, cmp_mismatch;

  always_comb begin
    cur_block    = phase_is_block(phase_q);
    cur_mode     = phase_mode(phase_q);
    op_len       = cur_block ? BC_W'(BURST) : BC_W'(1);
    wr_addr      = base_q + ADDR_W'(beat_q);
    mm_write     = (state_q == ST_WR);
    mm_read      = (state_q == ST_RD) && !q_full;
    mm_address   = base_q;
    mm_burstcount = (mm_write || mm_read) ? op_len : '0;
    mm_writedata = mm_write ? DATA_W'(pattern_word(32'(wr_addr), tag_q)) : '0;
    op_pick      = (state_q == ST_PICK) && !cmp_err && (phase_q != PH_END);
    wr_beat_acc  = mm_write && !mm_waitrequest;
    rd_cmd_acc   = mm_read && !mm_waitrequest;
    last_wr_beat = (beat_q == op_len - 1'b1);
    phase_done   = (32'(opcnt_q) + 32'd1) >= phase_ops(int'(phase_q));
    test_pass    = (state_q == ST_PASS);
    test_fail    = (state_q == ST_FAIL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PICK;
      phase_q <= next_live(0);
      opcnt_q <= '0;
      beat_q  <= '0;
      tag_q   <= '0;
    end else begin
      case (state_q)
        ST_PICK: begin
          beat_q <= '0;
          if (op_pick) state_q <= ST_WR;
          else         state_q <= ST_DRAIN;
        end
        ST_WR: begin
          if (wr_beat_acc) begin
            if (last_wr_beat) begin
              state_q <= ST_RD;
              beat_q  <= '0;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ST_RD: begin
          if (rd_cmd_acc) begin
            tag_q   <= tag_q + 1'b1;
            state_q <= ST_PICK;
            if (phase_done) begin
              opcnt_q <= '0;
              phase_q <= next_live(int'(phase_q) + 1);
            end else begin
              opcnt_q <= opcnt_q + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (q_empty) state_q <= cmp_err ? ST_FAIL : ST_PASS;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  mem_bist_addr #(
    .ADDR_W(ADDR_W), .BURST(BURST), .SEED(SEED), .MIX_SEQ_WEIGHT(MIX_SEQ_WEIGHT)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .step_i(op_pick), .mode_i(cur_mode),
    .block_i(cur_block), .base_o(base_q)
  );

  mem_bist_expq #(.W(DESC_W), .DEPTH(QDEPTH)) u_expq (
    .clk(clk), .rst_n(rst_n), .push_i(rd_cmd_acc),
    .din_i({base_q, cur_block, tag_q}), .pop_i(q_pop),
    .head_o(q_head), .full_o(q_full), .empty_o(q_empty)
  );

  mem_bist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST(BURST)) u_cmp (
    .clk(clk), .rst_n(rst_n), .rdvalid_i(mm_readdatavalid), .rdata_i(mm_readdata),
    .q_empty_i(q_empty),
    .head_addr_i(q_head[DESC_W-1 -: ADDR_W]),
    .head_blk_i(q_head[TAG_W]),
    .head_tag_i(q_head[TAG_W-1:0]),
    .pop_o(q_pop), .mismatch_o(cmp_mismatch), .err_o(cmp_err)
  );

  // R8: a stalled command holds every field
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_write || mm_read) && mm_waitrequest |=>
      $stable(mm_write) && $stable(mm_read) && $stable(mm_address) &&
      $stable(mm_burstcount) && $stable(mm_writedata));
  // R9: no read is offered while the expected-data queue is full
  a_r9_no_read_full: assert property (@(posedge clk) disable iff (!rst_n)
    mm_read |-> !q_full);
  // R3: read and write are never offered together
  a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_read && mm_write));
  // R3: commands carry one beat or a full burst
  a_r3_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read || mm_write) |-> (mm_burstcount == BC_W'(1) || mm_burstcount == BC_W'(BURST)));
  // R10: pass is terminal, clean and drained
  a_r10_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    test_pass |=> test_pass && !mm_read && !mm_write);
  a_r10_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    test_pass |-> !cmp_err && q_empty);
  // R11: fail is terminal and exclusive with pass
  a_r11_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    test_fail |=> test_fail && !test_pass);
  a_r11_mismatch_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_mismatch |=> !test_pass);

endmodule

// File: tb/mem_bist_seq_tb_top.sv
module mem_bist_seq_tb_top;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BURST  = 4;
  localparam int QDEPTH = 3;
  localparam int BC_W   = $clog2(BURST + 1);
  localparam int N_SS = 5, N_SR = 10, N_SM = 0, N_BS = 3, N_BR = 4, N_BM = 16;
  localparam logic [7:0]  WEIGHT = 8'd100;
  localparam logic [31:0] SEED   = 32'hACE1_2468;
  localparam int TOTAL = N_SS + N_SR + N_SM + N_BS + N_BR + N_BM;
  localparam int OPS_TAB [6] = '{N_SS, N_SR, N_SM, N_BS, N_BR, N_BM};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              mm_waitrequest = 1'b0;
  logic              mm_read, mm_write;
  logic [ADDR_W-1:0] mm_address;
  logic [DATA_W-1:0] mm_writedata;
  logic [BC_W-1:0]   mm_burstcount;
  logic [DATA_W-1:0] mm_readdata = '0;
  logic              mm_readdatavalid = 1'b0;
  logic              test_pass, test_fail;

  mem_bist_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST(BURST), .QDEPTH(QDEPTH),
    .N_SS(N_SS), .N_SR(N_SR), .N_SM(N_SM), .N_BS(N_BS), .N_BR(N_BR), .N_BM(N_BM),
    .MIX_SEQ_WEIGHT(WEIGHT), .SEED(SEED)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mm_waitrequest(mm_waitrequest),
    .mm_read(mm_read), .mm_write(mm_write), .mm_address(mm_address),
    .mm_writedata(mm_writedata), .mm_burstcount(mm_burstcount),
    .mm_readdata(mm_readdata), .mm_readdatavalid(mm_readdatavalid),
    .test_pass(test_pass), .test_fail(test_fail)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench restatement of the LFSR step, bit by bit (taps 31,21,1,0)
  function automatic logic [31:0] b_step(input logic [31:0] s);
    logic [31:0] n;
    n = {1'b0, s[31:1]};
    n[31] = s[0];
    n[21] = s[22] ^ s[0];
    n[1]  = s[2] ^ s[0];
    n[0]  = s[1] ^ s[0];
    return n;
  endfunction

  function automatic logic [31:0] b_word(input int unsigned a, input int unsigned t);
    logic [31:0] prod;
    prod = a * 32'h9E37_79B1;
    return prod ^ ((t & 32'hFFFF) << 16) ^ 32'h0000_5A5A;
  endfunction

  function automatic int b_next(input int from);
    for (int i = from; i < 6; i++) if (OPS_TAB[i] != 0) return i;
    return 6;
  endfunction

  // ---------------- behavioural RAM responder ----------------
  logic [DATA_W-1:0] mem [1 << ADDR_W];
  int          lat = 20;
  bit          corrupt_en = 0;
  int          beat_ret = 0;
  int          wb_r = 0;
  longint      cyc = 0;
  logic [DATA_W-1:0] pend_data [$];
  longint      pend_time [$];
  logic        inject_flag = 1'b0;

  initial for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mm_waitrequest   <= 1'b0;
      mm_readdatavalid <= 1'b0;
      inject_flag      <= 1'b0;
      pend_data.delete();
      pend_time.delete();
      wb_r = 0;
      beat_ret = 0;
    end else begin
      if (mm_write && !mm_waitrequest) begin
        mem[ADDR_W'(mm_address + ADDR_W'(wb_r))] <= mm_writedata;
        wb_r = (wb_r + 1 == int'(mm_burstcount)) ? 0 : wb_r + 1;
      end
      if (mm_read && !mm_waitrequest) begin
        for (int i = 0; i < int'(mm_burstcount); i++) begin
          pend_data.push_back(mem[ADDR_W'(mm_address + ADDR_W'(i))]);
          pend_time.push_back(cyc + lat);
        end
      end
      if (pend_data.size() > 0 && cyc >= pend_time[0] && ($urandom_range(2) != 0)) begin
        mm_readdatavalid <= 1'b1;
        inject_flag      <= corrupt_en && (beat_ret == 2);
        mm_readdata      <= pend_data[0] ^ ((corrupt_en && beat_ret == 2) ? 32'h1 : 32'h0);
        void'(pend_data.pop_front());
        void'(pend_time.pop_front());
        beat_ret++;
      end else begin
        mm_readdatavalid <= 1'b0;
        inject_flag      <= 1'b0;
      end
      mm_waitrequest <= ($urandom_range(3) == 0);
    end
  end

  // ---------------- bench model and port checks ----------------
  int          b_phase, b_cnt, tag;
  logic [31:0] b_lfsr;
  logic [ADDR_W-1:0] b_seq, cur_base;
  bit          in_op;
  int          cur_len, wbeat, outstanding, max_out, withheld, rbeat;
  int          rd_lens [$];
  int          ops_started, ops_after_err, mix_seq, mix_rand;
  bit          err_seen, pass_seen, fail_seen;
  bit          p_pend, p_wr, p_rd;
  logic [ADDR_W-1:0] p_addr;
  logic [BC_W-1:0]   p_bc;
  logic [DATA_W-1:0] p_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      b_phase = b_next(0); b_cnt = 0; tag = 0; b_lfsr = SEED; b_seq = '0;
      in_op = 0; cur_len = 0; wbeat = 0; outstanding = 0; max_out = 0;
      withheld = 0; rbeat = 0; rd_lens.delete(); ops_started = 0;
      ops_after_err = 0; mix_seq = 0; mix_rand = 0; err_seen = 0;
      pass_seen = 0; fail_seen = 0; p_pend = 0; cur_base = '0;
    end else begin
      if (p_pend) begin
        check(mm_write == p_wr && mm_read == p_rd, "R8", "command held", {mm_write, mm_read}, {p_wr, p_rd});
        check(mm_address == p_addr && mm_burstcount == p_bc, "R8", "address/burst held", mm_address, p_addr);
        if (p_wr) check(mm_writedata == p_data, "R8", "writedata held", mm_writedata, p_data);
      end
      if (mm_write) begin
        if (!in_op) begin
          int mode, len;
          bit us;
          logic [ADDR_W-1:0] eb;
          if (b_phase >= 6) begin
            check(0, "R2", "operation after last phase", b_phase, 6);
            len = int'(mm_burstcount);
          end else begin
            mode = b_phase % 3;
            len  = (b_phase >= 3) ? BURST : 1;
            us   = 1;
            if (mode != 0) begin
              b_lfsr = b_step(b_lfsr);
              us = (mode == 2) && (b_lfsr[31:24] < WEIGHT);
              if (mode == 2) begin
                if (us) mix_seq++; else mix_rand++;
              end
            end
            eb = us ? b_seq : b_lfsr[ADDR_W-1:0];
            if (us) b_seq = b_seq + ADDR_W'(len);
            if (mode == 0) check(mm_address == eb, "R4", "sequential base", mm_address, eb);
            else if (mode == 1) check(mm_address == eb, "R5", "random base", mm_address, eb);
            else check(mm_address == eb, "R6", "mixed base", mm_address, eb);
            check(int'(mm_burstcount) == len, "R3", "write burstcount", mm_burstcount, len);
            b_cnt++;
            if (b_cnt == OPS_TAB[b_phase]) begin
              b_cnt = 0;
              b_phase = b_next(b_phase + 1);
            end
          end
          in_op = 1; cur_base = mm_address; cur_len = len; wbeat = 0;
          ops_started++;
          if (err_seen) ops_after_err++;
        end
        if (!mm_waitrequest) begin
          logic [31:0] ew;
          ew = b_word(int'(ADDR_W'(cur_base + ADDR_W'(wbeat))), tag);
          check(mm_writedata == ew, "R7", "write word", mm_writedata, ew);
          check(wbeat < cur_len, "R3", "write beats per command", wbeat, cur_len);
          wbeat++;
        end
      end
      if (mm_read) begin
        check(in_op && wbeat == cur_len, "R3", "read after all write beats", wbeat, cur_len);
        check(mm_address == cur_base && int'(mm_burstcount) == cur_len, "R3",
              "read matches write set", mm_address, cur_base);
        if (!mm_waitrequest) begin
          check(outstanding < QDEPTH, "R9", "outstanding at read accept", outstanding, QDEPTH);
          outstanding++;
          if (outstanding > max_out) max_out = outstanding;
          rd_lens.push_back(cur_len);
          in_op = 0;
          tag++;
        end
      end
      if (!mm_read && !mm_write && in_op && wbeat == cur_len && outstanding == QDEPTH)
        withheld++;
      if (mm_readdatavalid) begin
        if (inject_flag) err_seen = 1;
        rbeat++;
        if (rd_lens.size() > 0 && rbeat == rd_lens[0]) begin
          void'(rd_lens.pop_front());
          rbeat = 0;
          outstanding--;
        end
      end
      if (test_pass && !pass_seen) begin
        pass_seen = 1;
        check(outstanding == 0 && !in_op, "R10", "pass with reads outstanding", outstanding, 0);
        check(b_phase == 6, "R10", "pass before all phases", b_phase, 6);
      end
      if (test_fail && !fail_seen) begin
        fail_seen = 1;
        check(outstanding == 0, "R11", "fail with reads outstanding", outstanding, 0);
      end
      p_pend = (mm_write || mm_read) && mm_waitrequest;
      p_wr = mm_write; p_rd = mm_read; p_addr = mm_address;
      p_bc = mm_burstcount; p_data = mm_writedata;
    end
  end

  task automatic wait_verdict(input string req);
    int n;
    n = 0;
    while (!(test_pass || test_fail) && n < 60000) begin
      @(negedge clk);
      n++;
    end
    if (!(test_pass || test_fail)) check(0, req, "watchdog expired", n, 60000);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!mm_read && !mm_write, "R1", "commands in reset", {mm_read, mm_write}, 0);
    check(!test_pass && !test_fail, "R1", "verdict in reset", {test_pass, test_fail}, 0);
    rst_n = 1'b1;

    // run 1: clean memory, slow responses
    wait_verdict("R10");
    @(negedge clk);
    check(test_pass == 1'b1, "R10", "pass reached", test_pass, 1);
    check(test_fail == 1'b0, "R10", "no fail on clean run", test_fail, 0);
    check(ops_started == TOTAL, "R2", "operations per run", ops_started, TOTAL);
    check(mix_seq > 0 && mix_rand > 0, "R6", "both mixed choices", mix_seq, mix_rand);
    check(max_out == QDEPTH, "R9", "queue filled", max_out, QDEPTH);
    check(withheld > 0, "R9", "read withheld when full", withheld, 1);
    repeat (20) @(negedge clk);
    check(test_pass && !mm_read && !mm_write, "R10", "pass terminal and idle", test_pass, 1);

    // run 2: one corrupted beat, fast responses
    rst_n = 1'b0;
    lat = 3;
    corrupt_en = 1;
    repeat (4) @(negedge clk);
    check(!test_pass && !test_fail, "R1", "verdict cleared by reset", {test_pass, test_fail}, 0);
    rst_n = 1'b1;
    wait_verdict("R11");
    @(negedge clk);
    check(err_seen == 1'b1, "R11", "corruption delivered", err_seen, 1);
    check(test_fail == 1'b1, "R11", "fail reached", test_fail, 1);
    check(test_pass == 1'b0, "R11", "no pass after mismatch", test_pass, 0);
    check(ops_after_err <= 1, "R11", "ops started after mismatch", ops_after_err, 1);
    check(ops_started < TOTAL, "R11", "sequence stopped early", ops_started, TOTAL);
    repeat (20) @(negedge clk);
    check(test_fail && !test_pass && !mm_read && !mm_write, "R11", "fail terminal", test_fail, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule